// File: doc/BRIEF.md
# Cascadable Serial Command and Fault Readback Port

This block is the serial slave port of a four-channel low-side gate predriver. A controller lowers the select line, toggles the serial clock and streams command bits into the data input. At the moment select falls, the port takes a snapshot of the per-channel fault levels into its shift register. Those fault bits leave on the serial output first, highest channel first. After them come the command bits that were shifted in, so several ports can be chained with each serial output feeding the next serial input. When select rises, the four bits left in the shift register become the channel control word.

Every gate enable is the OR of its control bit and a dedicated parallel input pin. The parallel path is combinational, so it needs neither the serial clock nor select. The three serial pins and the fault levels come from outside the block's clock domain. They are oversampled by a fast system clock through two-flop synchronizers, and all edge detection happens in that domain. The serial output is a data line plus an output enable, and the pad turns the pair into a three-state driver.

There is no streaming payload, so the port has no valid/ready handshake. The serial clock sets the pace, and the controller must hold each pin level for at least three system clocks.

Top module: `casc_ctl_port`

## Requirements
- R1: When select falls, the four fault levels are loaded into the shift register, the output enable goes high, and the serial output shows the channel 3 fault bit before the first serial clock.
- R2: While selected, each serial-clock rise shifts the data input into bit 0 of the shift register, and each fall presents bit 3 on the serial output. The output therefore carries fault bits for channel 3 down to channel 0, followed by the data bits in the order they were received.
- R3: When select rises, the shift register is copied into the control register and the output enable drops. Control bit k (1 = on) belongs to channel k, and the first bit received after the last four lands in bit 3.
- R4: With exactly four clocks the control word equals the four bits sent. With fewer clocks the leftover fault bits fill the upper control bits. With more clocks only the last four bits sent count.
- R5: Fault levels that change while select is low do not alter the bits shifted out in that transfer.
- R6: Gate enable k equals control bit k OR parallel input k, with no clock involved.
- R7: An active-low reset clears the shift and control registers and drops the output enable, so the gates follow only the parallel inputs.
- R8: Serial-clock activity while select is high changes neither the control register nor the next fault snapshot.
- R9: Between transfers the control register holds its value, and the output enable stays low while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_pin | input | 1 | Serial select, active low |
| sck_pin | input | 1 | Serial clock |
| sdi_pin | input | 1 | Serial data input |
| fault_lvl_i | input | 4 | Live per-channel fault levels, bit k = channel k |
| par_on_i | input | 4 | Parallel channel enables |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Serial output enable (low = high impedance) |
| ctrl_o | output | 4 | Control register |
| gate_on_o | output | 4 | Gate enables to the drivers |

## Verification
For four-clock transfers the bench sweeps every pair of fault snapshot and command word. This separates a swapped bit order, a wrong fault channel mapping and a broken commit. Transfer lengths from zero to eight clocks show that short frames keep leftover fault bits and that long frames keep only the last four bits, with the earlier bits passed through. Other runs change the faults in the middle of a frame, toggle the clock while deselected, assert reset in the middle of a frame, and sweep the parallel inputs against several control words. These show that the snapshot, the deselected state and the OR path stay independent.

// File: rtl/casc_ctl_pkg.sv
package casc_ctl_pkg;
  typedef enum logic {
    PORT_IDLE = 1'b0,
    PORT_SEL  = 1'b1
  } port_state_e;

  localparam int unsigned DEF_CHANNELS    = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/casc_sync.sv
module casc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/casc_edge.sv
module casc_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/casc_shift_engine.sv
module casc_shift_engine
  import casc_ctl_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_fall_i,
  input  logic           sel_rise_i,
  input  logic           sck_rise_i,
  input  logic           sck_fall_i,
  input  logic           sdi_i,
  input  logic [NCH-1:0] fault_i,
  output logic           sdo_o,
  output logic           sdo_oe_o,
  output logic [NCH-1:0] ctrl_o
);
  localparam int unsigned MSB = NCH - 1;

  port_state_e    state_q;
  logic [NCH-1:0] sr_q;
  logic [NCH-1:0] ctrl_q;
  logic           sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PORT_IDLE;
      sr_q    <= '0;
      ctrl_q  <= '0;
      sdo_q   <= 1'b0;
    end else begin
      unique case (state_q)
        PORT_IDLE: begin
          if (sel_fall_i) begin
            sr_q    <= fault_i;
            sdo_q   <= fault_i[MSB];
            state_q <= PORT_SEL;
          end
        end
        PORT_SEL: begin
          if (sel_rise_i) begin
            ctrl_q  <= sr_q;
            sr_q    <= '0;
            state_q <= PORT_IDLE;
          end else begin
            if (sck_rise_i) sr_q  <= {sr_q[MSB-1:0], sdi_i};
            if (sck_fall_i) sdo_q <= sr_q[MSB];
          end
        end
        default: state_q <= PORT_IDLE;
      endcase
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = (state_q == PORT_SEL);
  assign ctrl_o   = ctrl_q;

  AST_SNAPSHOT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PORT_IDLE && sel_fall_i) |=> (sdo_oe_o && sdo_q == $past(fault_i[MSB]))); // R1
  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PORT_SEL && sck_rise_i && !sel_rise_i) |=> (sr_q[0] == $past(sdi_i))); // R2
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PORT_SEL && !sck_fall_i) |=> $stable(sdo_q)); // R2
  AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PORT_SEL && sel_rise_i) |=> (ctrl_q == $past(sr_q) && !sdo_oe_o)); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == PORT_SEL && sel_rise_i) |=> $stable(ctrl_q)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (ctrl_q == '0 && !sdo_oe_o)); // R7
endmodule

// File: rtl/casc_ctl_port.sv
module casc_ctl_port
  import casc_ctl_pkg::*;
#(
  parameter int unsigned NCH         = DEF_CHANNELS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_n_pin,
  input  logic           sck_pin,
  input  logic           sdi_pin,
  input  logic [NCH-1:0] fault_lvl_i,
  input  logic [NCH-1:0] par_on_i,
  output logic           sdo_o,
  output logic           sdo_oe_o,
  output logic [NCH-1:0] ctrl_o,
  output logic [NCH-1:0] gate_on_o
);
  localparam int unsigned PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic [NCH-1:0]   fault_s;
  logic sel_rise, sel_fall, sck_rise, sck_fall;
  logic sdo_raw, oe;

  casc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sel_n_pin, sck_pin, sdi_pin}),
    .sync_o(pins_s)
  );

  casc_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_fault_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i(fault_lvl_i),
    .sync_o(fault_s)
  );

  casc_edge #(.RST_VAL(1'b1)) u_sel_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pins_s[2]),
    .rise_o(sel_rise), .fall_o(sel_fall)
  );

  casc_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pins_s[1]),
    .rise_o(sck_rise), .fall_o(sck_fall)
  );

  casc_shift_engine #(.NCH(NCH)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .sel_fall_i(sel_fall), .sel_rise_i(sel_rise),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .sdi_i(pins_s[0]), .fault_i(fault_s),
    .sdo_o(sdo_raw), .sdo_oe_o(oe), .ctrl_o(ctrl_o)
  );

  assign sdo_oe_o = oe;
  assign sdo_o    = oe ? sdo_raw : 1'b0;

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_gate
      assign gate_on_o[k] = ctrl_o[k] | par_on_i[k];
    end
  endgenerate

  AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_s[2] && $past(pins_s[2]) && !sel_fall) |=> !sdo_oe_o); // R9
endmodule

// File: tb/tb_casc_ctl_port.sv
module tb_casc_ctl_port;
  localparam int NCH = 4;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [NCH-1:0] flt = '0, par = '0;
  logic sdo, oe;
  logic [NCH-1:0] ctrl, gate;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  casc_ctl_port dut (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sck_pin(sck), .sdi_pin(sdi),
    .fault_lvl_i(flt), .par_on_i(par), .sdo_o(sdo), .sdo_oe_o(oe),
    .ctrl_o(ctrl), .gate_on_o(gate)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one frame: fault snapshot f, n clocks, bits sent from d[n-1] down to d[0].
  // If flip is set, fault levels are inverted right after select falls (R5).
  task automatic frame(input logic [3:0] f, input int n, input logic [15:0] d, input bit flip);
    logic stream [24];
    logic [15:0] got, expo;
    logic [3:0] expc;
    for (int i = 0; i < 4; i++) stream[i] = f[3-i];
    for (int i = 0; i < n; i++) stream[4+i] = d[n-1-i];
    flt = f;
    wclk(GAP);
    sel_n = 1'b0;
    wclk(GAP);
    if (flip) flt = ~f;
    chk("R1 oe", {31'd0, oe}, 32'd1);
    chk("R1 first bit", {31'd0, sdo}, {31'd0, stream[0]});
    got = '0; expo = '0;
    for (int i = 0; i < n; i++) begin
      sdi = d[n-1-i];
      wclk(GAP);
      sck = 1'b1;
      wclk(GAP);
      sck = 1'b0;
      wclk(GAP);
      got[i] = sdo;
      expo[i] = stream[i+1];
    end
    if (n > 0) chk(flip ? "R5 stream" : "R2 stream", {16'd0, got}, {16'd0, expo});
    sel_n = 1'b1;
    wclk(GAP);
    for (int i = 0; i < 4; i++) expc[3-i] = stream[n+i];
    chk(n == 4 ? "R3 commit" : "R4 commit", {28'd0, ctrl}, {28'd0, expc});
    chk("R3 oe off", {31'd0, oe}, 32'd0);
  endtask

  initial begin
    wclk(3);
    chk("R7 reset ctrl", {28'd0, ctrl}, 32'd0);
    chk("R7 reset oe", {31'd0, oe}, 32'd0);
    rst_n = 1'b1;
    wclk(4);
    // R2 R3: exhaustive four-clock sweep
    for (int f = 0; f < 16; f++)
      for (int d = 0; d < 16; d++)
        frame(f[3:0], 4, {12'd0, d[3:0]}, 1'b0);
    // R4: short and long frames
    for (int n = 0; n <= 8; n++) begin
      frame(4'b1010, n, 16'h00C5, 1'b0);
      frame(4'b0111, n, 16'h003A, 1'b0);
    end
    // R5: faults change mid-frame
    frame(4'b1001, 4, 16'h0006, 1'b1);
    frame(4'b0110, 6, 16'h0011, 1'b1);
    // R8: clocks while deselected are ignored
    frame(4'b0000, 4, 16'h0009, 1'b0);
    for (int i = 0; i < 5; i++) begin
      sdi = i[0]; wclk(GAP); sck = 1'b1; wclk(GAP); sck = 1'b0; wclk(GAP);
    end
    chk("R8 ctrl kept", {28'd0, ctrl}, 32'h9);
    chk("R9 oe idle", {31'd0, oe}, 32'd0);
    flt = 4'b1100; wclk(GAP); sel_n = 1'b0; wclk(GAP);
    chk("R8 snapshot msb", {31'd0, sdo}, 32'd1);
    sel_n = 1'b1; wclk(GAP);
    chk("R8 zero-clock commit", {28'd0, ctrl}, 32'hC);
    // R6: parallel OR path
    for (int c = 0; c < 4; c++) begin
      frame(4'b0000, 4, {12'd0, 4'(c * 5)}, 1'b0);
      for (int p = 0; p < 16; p++) begin
        par = p[3:0];
        #1;
        chk("R6 gate", {28'd0, gate}, {28'd0, 4'(c * 5) | p[3:0]});
      end
    end
    par = '0;
    // R7: reset mid-frame
    frame(4'b0000, 4, 16'h000F, 1'b0);
    sel_n = 1'b0; wclk(GAP);
    rst_n = 1'b0; wclk(2);
    chk("R7 mid ctrl", {28'd0, ctrl}, 32'd0);
    chk("R7 mid oe", {31'd0, oe}, 32'd0);
    chk("R7 mid gate", {28'd0, gate}, 32'd0);
    sel_n = 1'b1; wclk(2); rst_n = 1'b1; wclk(GAP);
    chk("R9 hold after reset", {28'd0, ctrl}, 32'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule